// File: doc/BRIEF.md
# IBI Payload Slicing Queue Packer

When an in-band interrupt finishes on the serial bus, this block turns the payload bytes collected during the interrupt into a sequence of 32-bit words in a small queue. Software drains that queue through a read port. The payload is cut into slices of a configurable size. Each slice is written as a header word that carries the slice length and a last-slice flag, followed by the slice's bytes packed four to a word.

The upstream bus logic pushes payload bytes into an internal byte store. When the interrupt ends, it pulses a done strobe together with three things: the status bits that go into every header, whether the request was refused, and whether refused requests should be reported at all. The block then packs the payload at one byte per clock and holds `busy` high while it does so. It reports the queue fill level and the number of headers in the latest report, and it drives an interrupt that follows queue occupancy against a programmable threshold.

Top module: `ibi_slice_packer`

## Requirements
- R1: After reset, `q_level`, `status_count`, `thld_irq` and `busy` are 0, and `q_rd_data` reads 0.
- R2: The slice size in bytes is 4 × `data_thld`. A `data_thld` of 0 counts as 1, and any product of 64 or more becomes 63.
- R3: If `ibi_nacked` is 1 and `nack_notify_en` is 0 at the done strobe, the block writes no word to the queue and never raises `busy`. It also discards the stored payload and leaves `status_count` unchanged.
- R4: A report with no payload writes exactly one header, with length 0 and the last flag set, and sets `status_count` to 1.
- R5: The header layout is: length in bits [7:0], `ibi_status` in bits [30:8], and the last flag in bit 31. The length field is computed anew for each slice. Every slice except the final one has length equal to the slice size and last flag 0. The final slice has the remaining byte count and last flag 1.
- R6: Payload bytes follow their slice's header in arrival order. The first byte of each word sits in bits [7:0], the next in [15:8], and so on. A word closes after its fourth byte or at the end of its slice, and unused upper bytes read as 0.
- R7: The interrupt threshold is `stat_thld` + 1. `thld_irq` rises when a queue write brings the level to the threshold or above. It falls when a read brings the level below the threshold.
- R8: The queue holds 16 words, and writes to a full queue are dropped. `q_rd_data` shows the oldest word, and `q_rd_en` removes it. Reading an empty queue returns 0 and leaves the level at 0.
- R9: The byte store holds 128 bytes, and bytes beyond that are dropped. Bytes offered while `busy` is high or during the done strobe are ignored.
- R10: Packing takes one cycle per header and one cycle per payload byte. `busy` is high for exactly that many cycles, starting in the cycle after the done strobe.
- R11: `status_count` equals the number of headers written by the most recent report that was not suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_byte_valid | input | 1 | Payload byte strobe |
| in_byte | input | 8 | Payload byte |
| ibi_done | input | 1 | One-cycle strobe: interrupt finished, start packing |
| ibi_nacked | input | 1 | The request was refused |
| nack_notify_en | input | 1 | Report refused requests as well |
| ibi_status | input | 23 | Status bits copied into header bits [30:8] |
| data_thld | input | 5 | Slice size field (units of 4 bytes) |
| stat_thld | input | 4 | Interrupt threshold minus one |
| q_rd_en | input | 1 | Pop the oldest queue word |
| q_rd_data | output | 32 | Oldest queue word, 0 when empty |
| q_level | output | 5 | Words in the queue |
| status_count | output | 8 | Headers in the latest report |
| thld_irq | output | 1 | Queue occupancy interrupt |
| busy | output | 1 | Packing in progress |

## Verification
The assertions check the following on every cycle:
- the queue and the byte store never exceed their depth;
- a full queue stays full when a write is refused;
- the interrupt only rises at or above the threshold and only falls below it;
- the packer advances exactly one byte per payload cycle;
- no header length exceeds the slice size;
- a suppressed report never leaves the idle state.

Other behaviours can only be shown by the bench's scenarios, which compare against a model of the slicing:
- the exact header and data word contents, including zero padding and the 63-byte clamp;
- the busy duration;
- the payload being discarded on suppression;
- bytes dropped when the store is full or the packer is busy.

// File: rtl/ibi_pack_pkg.sv
// Shared types and helpers for the IBI slice packer.
// Assumes headers are 32 bits with an 8-bit length field.
package ibi_pack_pkg;
    localparam int WORD_W = 32;
    localparam int LEN_W  = 8;
    localparam int DTH_W  = 5;
    localparam int STAT_W = 23;

    typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_DATA} pk_state_e;

    // Slice size from the threshold field: 0 acts as 1, x4, clamp at 63.
    function automatic logic [LEN_W-1:0] slice_bytes(input logic [DTH_W-1:0] fld);
        logic [LEN_W-1:0] m;
        m = (fld == '0) ? LEN_W'(1) : LEN_W'(fld);
        m = m << 2;
        if (m >= LEN_W'(64)) m = LEN_W'(63);
        return m;
    endfunction

    // Header word: last flag on top, status in the middle, length at the bottom.
    function automatic logic [WORD_W-1:0] make_hdr(input logic [STAT_W-1:0] st,
                                                   input logic [LEN_W-1:0] len,
                                                   input logic last);
        return {last, st, len};
    endfunction
endpackage

// File: rtl/ibi_byte_store.sv
// Byte store for the payload of one in-band interrupt.
// Appends bytes until full and drops any extra. Read is asynchronous by address.
// Assumes the clear and write strobes are never asserted together by the controller.
module ibi_byte_store #(
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          clr,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic [CW-1:0] fill
);
    logic [7:0] mem [DEPTH];
    logic       room;

    assign room    = (fill < CW'(DEPTH));
    assign rd_data = mem[rd_addr];

    // Storage write: append at the fill position while room remains.
    always_ff @(posedge clk) begin
        if (wr_en && room) mem[fill[AW-1:0]] <= wr_data;
    end

    // Fill counter: cleared after a report, counts accepted bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)            fill <= '0;
        else if (clr)          fill <= '0;
        else if (wr_en && room) fill <= fill + CW'(1);
    end

    p_fill_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH));
endmodule

// File: rtl/ibi_word_queue.sv
// Word queue read by software, with an occupancy threshold interrupt.
// Writes to a full queue are dropped. The read port shows the oldest word, or 0 when empty.
// Assumes DEPTH is a power of two.
module ibi_word_queue #(
    parameter int DEPTH = 16,
    parameter int W = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    input  logic [CW-1:0] thr,
    output logic [W-1:0]  rd_data,
    output logic [CW-1:0] level,
    output logic          irq
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          push, pop;
    logic [CW-1:0] level_nx;

    assign push     = wr_en && (level < CW'(DEPTH));
    assign pop      = rd_en && (level != '0);
    assign level_nx = level + CW'(push) - CW'(pop);
    assign rd_data  = (level == '0) ? '0 : mem[rp];

    // Storage write at the tail.
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wr_data;
    end

    // Pointers and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0; rp <= '0; level <= '0;
        end else begin
            if (push) wp <= wp + AW'(1);
            if (pop)  rp <= rp + AW'(1);
            level <= level_nx;
        end
    end

    // Interrupt: set by a write reaching the threshold, cleared by a read dropping below it.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  irq <= 1'b0;
        else if (push && !pop && level_nx >= thr)    irq <= 1'b1;
        else if (pop && !push && level_nx < thr)     irq <= 1'b0;
    end

    p_level_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));
    p_full_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (level == CW'(DEPTH) && wr_en && !rd_en) |=> (level == CW'(DEPTH)));
    p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (level >= thr));
    p_irq_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> (level < thr));
endmodule

// File: rtl/ibi_pack_ctrl.sv
// Packing controller: walks the byte store one byte per cycle, emitting a header
// per slice and closing data words after four bytes or at the end of a slice.
// Assumes ibi_done arrives only while idle and lasts one cycle.
module ibi_pack_ctrl
    import ibi_pack_pkg::*;
#(
    parameter int BUF_DEPTH = 128,
    localparam int AW = $clog2(BUF_DEPTH),
    localparam int CW = $clog2(BUF_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic              nacked,
    input  logic              notify,
    input  logic [STAT_W-1:0] status_in,
    input  logic [DTH_W-1:0]  dthld,
    input  logic [CW-1:0]     fill,
    input  logic [7:0]        buf_byte,
    output logic [AW-1:0]     buf_addr,
    output logic              buf_clr,
    output logic              accept,
    output logic              q_wr,
    output logic [WORD_W-1:0] q_wdata,
    output logic              busy,
    output logic [7:0]        status_cnt
);
    pk_state_e         state;
    logic [AW-1:0]     rd_ptr;
    logic [CW-1:0]     remain;
    logic [LEN_W-1:0]  size, slice_left, cur_len;
    logic [1:0]        lane;
    logic [WORD_W-1:0] acc, new_acc;
    logic [STAT_W-1:0] stat_lat;
    logic [7:0]        hdr_cnt;
    logic              cur_last, word_done, suppress, finishing;

    assign suppress  = nacked && !notify;
    assign cur_last  = (LEN_W'(remain) <= size);
    assign cur_len   = cur_last ? LEN_W'(remain) : size;
    assign new_acc   = acc | ({{(WORD_W-8){1'b0}}, buf_byte} << {lane, 3'b000});
    assign word_done = (lane == 2'd3) || (slice_left == LEN_W'(1));
    assign finishing = ((state == ST_HDR) && (cur_len == '0)) ||
                       ((state == ST_DATA) && (slice_left == LEN_W'(1)) && (remain == CW'(1)));
    assign buf_clr   = ((state == ST_IDLE) && done && suppress) || finishing;
    assign accept    = (state == ST_IDLE) && !done;
    assign busy      = (state != ST_IDLE);
    assign buf_addr  = rd_ptr;
    assign q_wr      = (state == ST_HDR) || ((state == ST_DATA) && word_done);
    assign q_wdata   = (state == ST_HDR) ? make_hdr(stat_lat, cur_len, cur_last) : new_acc;

    // Sequencer: idle -> header -> data bytes -> next header or back to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; rd_ptr <= '0; remain <= '0; size <= '0;
            slice_left <= '0; lane <= '0; acc <= '0; stat_lat <= '0;
            hdr_cnt <= '0; status_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (done && !suppress) begin
                    remain   <= fill;
                    size     <= slice_bytes(dthld);
                    stat_lat <= status_in;
                    rd_ptr   <= '0;
                    hdr_cnt  <= '0;
                    state    <= ST_HDR;
                end
                ST_HDR: begin
                    hdr_cnt    <= hdr_cnt + 8'd1;
                    slice_left <= cur_len;
                    lane       <= '0;
                    acc        <= '0;
                    if (cur_len == '0) begin
                        status_cnt <= hdr_cnt + 8'd1;
                        state      <= ST_IDLE;
                    end else begin
                        state <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    rd_ptr     <= rd_ptr + AW'(1);
                    remain     <= remain - CW'(1);
                    slice_left <= slice_left - LEN_W'(1);
                    lane       <= word_done ? 2'd0 : lane + 2'd1;
                    acc        <= word_done ? '0 : new_acc;
                    if (slice_left == LEN_W'(1)) begin
                        if (remain == CW'(1)) begin
                            status_cnt <= hdr_cnt;
                            state      <= ST_IDLE;
                        end else begin
                            state <= ST_HDR;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_byte_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |=> (rd_ptr == AW'($past(rd_ptr) + AW'(1))));
    p_len_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HDR) |-> (cur_len <= size));
    p_suppress_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && done && suppress) |=> (state == ST_IDLE));
endmodule

// File: rtl/ibi_slice_packer.sv
// Top: byte store, packing controller and software-read word queue.
// Assumes the bus side stops sending bytes once it raises ibi_done.
module ibi_slice_packer
    import ibi_pack_pkg::*;
#(
    parameter int BUF_DEPTH = 128,
    parameter int Q_DEPTH = 16,
    localparam int QCW = $clog2(Q_DEPTH + 1),
    localparam int QAW = $clog2(Q_DEPTH),
    localparam int BCW = $clog2(BUF_DEPTH + 1),
    localparam int BAW = $clog2(BUF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_byte_valid,
    input  logic [7:0]        in_byte,
    input  logic              ibi_done,
    input  logic              ibi_nacked,
    input  logic              nack_notify_en,
    input  logic [STAT_W-1:0] ibi_status,
    input  logic [DTH_W-1:0]  data_thld,
    input  logic [QAW-1:0]    stat_thld,
    input  logic              q_rd_en,
    output logic [WORD_W-1:0] q_rd_data,
    output logic [QCW-1:0]    q_level,
    output logic [7:0]        status_count,
    output logic              thld_irq,
    output logic              busy
);
    logic [BAW-1:0]    buf_addr;
    logic [7:0]        buf_byte;
    logic [BCW-1:0]    fill;
    logic              buf_clr, accept, q_wr;
    logic [WORD_W-1:0] q_wdata;
    logic [QCW-1:0]    thr;

    assign thr = QCW'(stat_thld) + QCW'(1);

    ibi_byte_store #(.DEPTH(BUF_DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(in_byte_valid && accept), .wr_data(in_byte),
        .clr(buf_clr), .rd_addr(buf_addr), .rd_data(buf_byte), .fill(fill));

    ibi_pack_ctrl #(.BUF_DEPTH(BUF_DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .done(ibi_done), .nacked(ibi_nacked),
        .notify(nack_notify_en), .status_in(ibi_status), .dthld(data_thld),
        .fill(fill), .buf_byte(buf_byte), .buf_addr(buf_addr), .buf_clr(buf_clr),
        .accept(accept), .q_wr(q_wr), .q_wdata(q_wdata), .busy(busy),
        .status_cnt(status_count));

    ibi_word_queue #(.DEPTH(Q_DEPTH), .W(WORD_W)) u_queue (
        .clk(clk), .rst_n(rst_n), .wr_en(q_wr), .wr_data(q_wdata), .rd_en(q_rd_en),
        .thr(thr), .rd_data(q_rd_data), .level(q_level), .irq(thld_irq));
endmodule

// File: tb/tb_ibi_slice_packer.sv
module tb_ibi_slice_packer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_byte_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        ibi_done = 1'b0, ibi_nacked = 1'b0, nack_notify_en = 1'b0;
    logic [22:0] ibi_status = '0;
    logic [4:0]  data_thld = '0;
    logic [3:0]  stat_thld = '0;
    logic        q_rd_en = 1'b0;
    logic [31:0] q_rd_data;
    logic [4:0]  q_level;
    logic [7:0]  status_count;
    logic        thld_irq, busy;

    ibi_slice_packer dut (.*);

    always #5 clk = ~clk;

    int checks = 0, failures = 0;
    logic [7:0]  pay [256];
    int          pn = 0;
    logic [31:0] expq [$];
    int          hdrs;
    logic [7:0]  last_cnt = '0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int slice_sz(input int f);
        int s;
        s = (f == 0) ? 1 : f;
        s = s * 4;
        if (s >= 64) s = 63;
        return s;
    endfunction

    // Expected queue contents for the current model payload.
    task automatic build_exp(input int sz, input logic [22:0] st);
        int pos = 0, rem = pn;
        expq.delete();
        hdrs = 0;
        if (pn == 0) begin
            expq.push_back({1'b1, st, 8'd0});
            hdrs = 1;
        end
        while (rem > 0) begin
            int len = (rem <= sz) ? rem : sz;
            logic [31:0] w = '0;
            expq.push_back({(rem <= sz), st, 8'(len)});
            hdrs++;
            for (int k = 0; k < len; k++) begin
                w = w | ({24'd0, pay[pos]} << (8 * (k % 4)));
                pos++;
                if ((k % 4) == 3 || k == len - 1) begin
                    expq.push_back(w);
                    w = '0;
                end
            end
            rem -= len;
        end
    endtask

    task automatic feed(input int n, input logic [7:0] base, input bit rnd);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b = rnd ? 8'($urandom) : base + 8'(i);
            @(negedge clk);
            in_byte_valid = 1'b1;
            in_byte = b;
            if (pn < 128) begin pay[pn] = b; pn++; end
        end
        @(negedge clk);
        in_byte_valid = 1'b0;
    endtask

    // Run one report and check it against the model; junk drives bytes while busy.
    task automatic report(input bit nack, input bit notify, input int fld, input int sthr,
                          input bit junk);
        int bc = 0, lvl, thr;
        logic [22:0] st = 23'($urandom);
        bit sup = nack && !notify;
        @(negedge clk);
        data_thld = 5'(fld); stat_thld = 4'(sthr); ibi_status = st;
        ibi_nacked = nack; nack_notify_en = notify; ibi_done = 1'b1;
        build_exp(slice_sz(fld), st);
        @(negedge clk);
        ibi_done = 1'b0;
        while (busy && bc < 1000) begin
            bc++;
            in_byte_valid = junk; in_byte = 8'hEE;
            @(negedge clk);
        end
        in_byte_valid = 1'b0;
        if (sup) begin
            check(bc == 0, "R3 busy", 32'(bc), 0);
            check(q_level == 0, "R3 level", 32'(q_level), 0);
            check(status_count == last_cnt, "R3 status_count", 32'(status_count), 32'(last_cnt));
            pn = 0;
            return;
        end
        check(bc == hdrs + pn, "R10 busy cycles", 32'(bc), 32'(hdrs + pn));
        check(status_count == 8'(hdrs), "R11 status_count", 32'(status_count), 32'(hdrs));
        last_cnt = 8'(hdrs);
        lvl = (expq.size() > 16) ? 16 : expq.size();
        thr = sthr + 1;
        check(q_level == 5'(lvl), "R8 level", 32'(q_level), 32'(lvl));
        check(thld_irq == (lvl >= thr), "R7 irq after report", 32'(thld_irq), 32'(lvl >= thr));
        for (int i = 0; i < lvl; i++) begin
            check(q_rd_data == expq[i], "R5/R6 word", q_rd_data, expq[i]);
            q_rd_en = 1'b1;
            @(negedge clk);
            q_rd_en = 1'b0;
            check(q_level == 5'(lvl - i - 1), "R8 level pop", 32'(q_level), 32'(lvl - i - 1));
            check(thld_irq == ((lvl - i - 1) >= thr), "R7 irq pop", 32'(thld_irq),
                  32'((lvl - i - 1) >= thr));
        end
        check(q_rd_data == 0, "R8 empty read", q_rd_data, 0);
        q_rd_en = 1'b1;
        @(negedge clk);
        q_rd_en = 1'b0;
        check(q_level == 0, "R8 empty pop level", 32'(q_level), 0);
        pn = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(q_level == 0, "R1 level", 32'(q_level), 0);
        check(status_count == 0, "R1 status_count", 32'(status_count), 0);
        check(thld_irq == 0, "R1 irq", 32'(thld_irq), 0);
        check(busy == 0, "R1 busy", 32'(busy), 0);
        check(q_rd_data == 0, "R1 read data", q_rd_data, 0);

        report(0, 0, 1, 0, 0);              // R4 empty payload
        feed(10, 8'h10, 0); report(0, 0, 1, 2, 0);   // R5 slices 4,4,2
        feed(5, 8'h30, 0);  report(0, 0, 0, 1, 0);   // R2 field 0 acts as 1
        feed(64, 8'h40, 0); report(0, 0, 16, 15, 0); // R2 clamp 63, R8 drop on full
        feed(8, 8'h50, 0);  report(0, 0, 2, 3, 0);   // R5 exact multiple
        feed(7, 8'h60, 0);  report(1, 0, 1, 0, 0);   // R3 suppressed
        feed(3, 8'h70, 0);  report(0, 0, 3, 0, 0);   // R3 old bytes discarded
        feed(6, 8'h80, 0);  report(1, 1, 1, 4, 1);   // R3 notified NACK, R9 junk while busy
        feed(2, 8'h90, 0);  report(0, 0, 1, 0, 0);   // R9 junk not stored
        feed(130, 8'h00, 0); report(0, 0, 31, 15, 0); // R9 store full drop, R10
        feed(13, 8'hA0, 0); report(0, 0, 31, 0, 0);  // R6 partial word padding

        for (int it = 0; it < 25; it++) begin
            feed($urandom_range(0, 40), 8'h00, 1);
            report($urandom_range(0, 3) == 0, 1'($urandom), $urandom_range(0, 31),
                   $urandom_range(0, 15), 1'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule